// File: doc/BRIEF.md
# Sequential Autocorrelation Engine

This block computes the full autocorrelation of a buffer of signed 16-bit samples that already sits in a two-port sample RAM. It uses a single multiplier and one accumulator. Two counters generate the operand addresses. An index counter drives the first read port. The second read port receives the index plus the current lag. Every clock cycle fetches exactly one operand pair. Their product is added into a wide signed accumulator. When the index reaches the end of the pass for the current lag, the finished sum is written to a result RAM at the address of that lag. The accumulator then restarts from zero, and the lag advances by one.

A host loads the samples, sets the buffer length on `n_len` and pulses `start` while `busy` is low. The engine works through every lag from 0 to N-1 with no stalls and raises `done` for one cycle together with the final result write. The memory ports have no handshake. Reads return data one cycle after the enable. Writes are taken in the cycle in which `res_wr_en` is high. Because the engine never applies or accepts back-pressure, the RAMs attached to it must accept one read pair and at most one write in every cycle.

Top module: `acorr_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `rd_a_en`, `rd_b_en` and `res_wr_en` are low.
- R2: For lag k, the engine issues reads with both enables high on consecutive cycles. Port A goes through addresses 0 to N-1-k in ascending order, and port B reads the port A address plus k. Lags are handled in order from 0 to N-1.
- R3: `rd_b_addr` never exceeds N-1 while `rd_b_en` is high.
- R4: The value written for lag k equals the sum over i of x[i]*x[i+k] as an exact two's-complement number of ACC_W bits. It never wraps for any length up to MAX_N with 16-bit samples, including full-scale negative inputs.
- R5: Each lag 0..N-1 is written exactly once, in ascending address order, with `res_wr_en` high for one cycle per lag.
- R6: `done` goes high exactly N(N+1)/2 + 2 cycles after the cycle in which `start` is accepted, in the same cycle as the write for lag N-1.
- R7: `busy` is high from the cycle after an accepted start until `done`, and it is low in the `done` cycle. A `start` seen while `busy` is high is ignored, and it does not change the results or the timing of the run in progress.
- R8: A start with `n_len` = 0 gives a `done` pulse in the next cycle, with no reads and no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when `busy` is low |
| n_len | input | LEN_W (11) | Number of samples N, sampled at an accepted start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| rd_a_en | output | 1 | Read enable, sample port A |
| rd_a_addr | output | ADDR_W (11) | Sample index address |
| rd_a_data | input | SAMPLE_W (16) | Port A data, one cycle after enable |
| rd_b_en | output | 1 | Read enable, sample port B |
| rd_b_addr | output | ADDR_W (11) | Index plus lag address |
| rd_b_data | input | SAMPLE_W (16) | Port B data, one cycle after enable |
| res_wr_en | output | 1 | Result write strobe |
| res_wr_addr | output | ADDR_W (11) | Lag being written |
| res_wr_data | output | ACC_W (43) | Signed autocorrelation sum |

## Verification
The bench builds the engine with its default parameters (MAX_N = 1500, 11-bit addresses, a 43-bit accumulator), so the address and accumulator widths are the ones a full buffer needs. It runs the engine on short buffers with random data and on 1, 2 and 0 samples. One 300-sample run at full negative scale drives the sums far past 32 bits, which tests the accumulator headroom within the cycle budget. A reference model of the address sequence tracks every read pair, and a start pulse injected during a run tests that such a pulse is ignored.

// File: rtl/acorr_pkg.sv
package acorr_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  function automatic int unsigned pair_count(input int unsigned n);
    return (n * (n + 1)) / 2;
  endfunction

endpackage

// File: rtl/acorr_addr_gen.sv
module acorr_addr_gen #(
  parameter int ADDR_W = 11,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [LEN_W-1:0]  len_in,
  output logic              running,
  output logic [ADDR_W-1:0] idx,
  output logic [ADDR_W-1:0] lag,
  output logic [ADDR_W-1:0] b_addr,
  output logic              pass_end,
  output logic              run_end
);
  import acorr_pkg::*;

  seq_state_e       state_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] span;
  logic [LEN_W-1:0] top_lag;

  assign running  = (state_q == SEQ_RUN);
  assign top_lag  = len_q - LEN_W'(1);
  assign span     = top_lag - LEN_W'(lag);
  assign pass_end = running && (LEN_W'(idx) == span);
  assign run_end  = pass_end && (LEN_W'(lag) == top_lag);
  assign b_addr   = idx + lag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx     <= '0;
      lag     <= '0;
      len_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (launch) begin
            state_q <= SEQ_RUN;
            idx     <= '0;
            lag     <= '0;
            len_q   <= len_in;
          end
        end
        SEQ_RUN: begin
          if (pass_end) begin
            idx <= '0;
            if (run_end) state_q <= SEQ_IDLE;
            else         lag     <= lag + ADDR_W'(1);
          end else begin
            idx <= idx + ADDR_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_B_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (LEN_W'(b_addr) <= top_lag)); // R3

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pass_end) |=> (running && idx == $past(idx) + ADDR_W'(1) && lag == $past(lag))); // R2

  AST_LAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_end && !run_end) |=> (running && idx == '0 && lag == $past(lag) + ADDR_W'(1))); // R2

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pass_end) |=> $stable(len_q)); // R7

endmodule

// File: rtl/acorr_mac.sv
module acorr_mac #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 11,
  parameter int ACC_W    = 43
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       issue_valid,
  input  logic                       issue_last,
  input  logic                       issue_final,
  input  logic [ADDR_W-1:0]          issue_lag,
  input  logic signed [SAMPLE_W-1:0] op_a,
  input  logic signed [SAMPLE_W-1:0] op_b,
  output logic                       in_flight,
  output logic                       wr_en,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic signed [ACC_W-1:0]    wr_data,
  output logic                       run_done
);
  localparam int PROD_W = 2 * SAMPLE_W;

  logic                     v_d, last_d, final_d;
  logic [ADDR_W-1:0]        lag_d;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  acc_next;
  logic signed [ACC_W:0]    acc_wide;

  assign prod      = op_a * op_b;
  assign acc_next  = acc_q + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign acc_wide  = {acc_q[ACC_W-1], acc_q} + {{(ACC_W+1-PROD_W){prod[PROD_W-1]}}, prod};
  assign in_flight = v_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_d     <= 1'b0;
      last_d  <= 1'b0;
      final_d <= 1'b0;
      lag_d   <= '0;
    end else begin
      v_d     <= issue_valid;
      last_d  <= issue_valid && issue_last;
      final_d <= issue_valid && issue_final;
      lag_d   <= issue_lag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      run_done <= 1'b0;
    end else begin
      wr_en    <= v_d && last_d;
      run_done <= v_d && final_d;
      if (v_d) begin
        if (last_d) begin
          acc_q   <= '0;
          wr_addr <= lag_d;
          wr_data <= acc_next;
        end else begin
          acc_q <= acc_next;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    v_d |-> (acc_wide[ACC_W] == acc_wide[ACC_W-1])); // R4

  AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |-> wr_en); // R6

  AST_CLEAR_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (v_d && last_d) |=> (acc_q == '0)); // R4

endmodule

// File: rtl/acorr_engine.sv
module acorr_engine #(
  parameter int SAMPLE_W = 16,
  parameter int MAX_N    = 1500,
  parameter int ADDR_W   = $clog2(MAX_N),
  parameter int LEN_W    = $clog2(MAX_N + 1),
  parameter int ACC_W    = 2 * SAMPLE_W + ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [LEN_W-1:0]           n_len,
  output logic                       busy,
  output logic                       done,
  output logic                       rd_a_en,
  output logic [ADDR_W-1:0]          rd_a_addr,
  input  logic signed [SAMPLE_W-1:0] rd_a_data,
  output logic                       rd_b_en,
  output logic [ADDR_W-1:0]          rd_b_addr,
  input  logic signed [SAMPLE_W-1:0] rd_b_data,
  output logic                       res_wr_en,
  output logic [ADDR_W-1:0]          res_wr_addr,
  output logic signed [ACC_W-1:0]    res_wr_data
);
  logic              accept, launch;
  logic              running, in_flight;
  logic              pass_end, run_end;
  logic              mac_done, empty_done;
  logic [ADDR_W-1:0] idx, lag, b_addr;

  assign busy   = running || in_flight;
  assign accept = start && !busy;
  assign launch = accept && (n_len != '0);

  acorr_addr_gen #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .len_in   (n_len),
    .running  (running),
    .idx      (idx),
    .lag      (lag),
    .b_addr   (b_addr),
    .pass_end (pass_end),
    .run_end  (run_end)
  );

  acorr_mac #(
    .SAMPLE_W (SAMPLE_W),
    .ADDR_W   (ADDR_W),
    .ACC_W    (ACC_W)
  ) u_mac (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (running),
    .issue_last  (pass_end),
    .issue_final (run_end),
    .issue_lag   (lag),
    .op_a        (rd_a_data),
    .op_b        (rd_b_data),
    .in_flight   (in_flight),
    .wr_en       (res_wr_en),
    .wr_addr     (res_wr_addr),
    .wr_data     (res_wr_data),
    .run_done    (mac_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) empty_done <= 1'b0;
    else        empty_done <= accept && (n_len == '0);
  end

  assign rd_a_en   = running;
  assign rd_b_en   = running;
  assign rd_a_addr = idx;
  assign rd_b_addr = b_addr;
  assign done      = mac_done || empty_done;

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7

  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    empty_done |-> (!rd_a_en && !res_wr_en)); // R8

endmodule

// File: tb/sim_acorr_engine.sv
module sim_acorr_engine;
  localparam int SAMPLE_W = 16;
  localparam int MAX_N    = 1500;
  localparam int ADDR_W   = $clog2(MAX_N);
  localparam int LEN_W    = $clog2(MAX_N + 1);
  localparam int ACC_W    = 2 * SAMPLE_W + ADDR_W;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] n_len = '0;
  logic busy, done, rd_a_en, rd_b_en, res_wr_en;
  logic [ADDR_W-1:0] rd_a_addr, rd_b_addr, res_wr_addr;
  logic signed [SAMPLE_W-1:0] rd_a_data, rd_b_data;
  logic signed [ACC_W-1:0] res_wr_data;

  logic signed [SAMPLE_W-1:0] mem [0:MAX_N-1];
  longint exp_res [0:MAX_N-1];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur_len = 0;
  int mon_idx = 0, mon_lag = 0, addr_err = 0;
  int wr_cnt = 0, wr_order_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acorr_engine #(.SAMPLE_W(SAMPLE_W), .MAX_N(MAX_N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .n_len(n_len),
    .busy(busy), .done(done),
    .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .res_wr_en(res_wr_en), .res_wr_addr(res_wr_addr), .res_wr_data(res_wr_data)
  );

  always @(posedge clk) begin
    if (rd_a_en) rd_a_data <= mem[rd_a_addr];
    if (rd_b_en) rd_b_data <= mem[rd_b_addr];
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Address-sequence model for R2/R3 and result checks for R4/R5
  always @(negedge clk) begin
    if (rst_n && rd_a_en) begin
      if (rd_a_addr != ADDR_W'(mon_idx) || rd_b_addr != ADDR_W'(mon_idx + mon_lag) ||
          !rd_b_en || int'(rd_b_addr) > cur_len - 1)
        addr_err++;
      if (mon_idx == cur_len - 1 - mon_lag) begin
        mon_idx = 0;
        mon_lag++;
      end else begin
        mon_idx++;
      end
    end
    if (rst_n && res_wr_en) begin
      if (int'(res_wr_addr) != wr_cnt) wr_order_err++;
      if (int'(res_wr_addr) < MAX_N)
        check(longint'(res_wr_data) == exp_res[res_wr_addr], "R4",
              longint'(res_wr_data), exp_res[res_wr_addr]);
      wr_cnt++;
    end
  end

  function automatic longint lag_sum(input int n, input int k);
    longint s = 0;
    for (int i = 0; i + k < n; i++) s += longint'(mem[i]) * longint'(mem[i + k]);
    return s;
  endfunction

  task automatic run_case(input int n, input bit inject);
    int c0;
    int guard;
    for (int k = 0; k < n; k++) exp_res[k] = lag_sum(n, k);
    cur_len = n; mon_idx = 0; mon_lag = 0; addr_err = 0; wr_cnt = 0; wr_order_err = 0;
    @(negedge clk);
    check(!busy, "R7", busy, 0);
    start = 1'b1; n_len = LEN_W'(n); c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    if (n > 0) check(busy == 1'b1, "R7", busy, 1);
    if (inject && n > 4) begin
      repeat (3) @(negedge clk);
      start = 1'b1; n_len = LEN_W'(n - 2);
      @(negedge clk);
      start = 1'b0; n_len = '0;
    end
    guard = 0;
    while (!done && !finished) begin
      @(negedge clk);
      guard++;
      if (guard > n * (n + 1) / 2 + 20 && n > 0) begin
        check(1'b0, "R6", guard, n * (n + 1) / 2 + 2);
        return;
      end
    end
    if (n == 0) check(cyc - c0 == 1, "R8", cyc - c0, 1);
    else        check(cyc - c0 == n * (n + 1) / 2 + 2, "R6", cyc - c0, n * (n + 1) / 2 + 2);
    check(!busy, "R7", busy, 0);
    if (n > 0) check(res_wr_en && int'(res_wr_addr) == n - 1, "R6", res_wr_addr, n - 1);
    @(negedge clk);
    check(!done, "R7", done, 0);
    check(addr_err == 0 && mon_lag == n, "R2", addr_err, 0);
    check(wr_cnt == n && wr_order_err == 0, "R5", wr_cnt, n);
    if (n == 0) check(wr_cnt == 0 && mon_lag == 0, "R8", wr_cnt, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MAX_N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_a_en && !rd_b_en && !res_wr_en, "R1", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rd_a_en && !res_wr_en, "R1", done, 0);

    mem[0] = 16'sd7;
    run_case(1, 1'b0);
    mem[0] = -16'sd3; mem[1] = 16'sd5;
    run_case(2, 1'b0);
    run_case(0, 1'b0);
    mem[0] = 16'sh7fff; mem[1] = -16'sh8000; mem[2] = 16'sh7fff;
    run_case(3, 1'b0);

    for (int r = 0; r < 10; r++) begin
      int n;
      n = 4 + int'($urandom_range(56));
      for (int i = 0; i < n; i++) mem[i] = SAMPLE_W'($urandom);
      run_case(n, r == 3);
    end

    for (int i = 0; i < 300; i++) mem[i] = -16'sh8000;
    run_case(300, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule